// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a 128-bit integer execution unit that treats its two operands as packed lanes. Each operation picks its own lane size: four 32-bit lanes, eight 16-bit lanes or sixteen 8-bit lanes. Arithmetic stays inside a lane, so one operation performs several independent narrow computations at once. Lane-wise operations are add, subtract, signed minimum and maximum, left and right shifts and a leading-zero count. Full-width operations are the bitwise logic functions and a funnel shift that extracts a 128-bit window from the 256-bit join of both operands.

The unit sits in an execute stage. The issuing logic presents both operands, an opcode, a lane-size code and a shift amount together with a valid strobe. One clock later the result appears on a register together with a matching valid flag. When the strobe is low, the result register keeps its value. Scalar addresses and integers are handled elsewhere. Only the operands are 128 bits wide.

Top module: `simd_alu`

## Requirements
- R1: While `rst_n` is low, `valid_out` is 0 and `result` is all zeros.
- R2: `valid_out` equals the `valid_in` of the previous cycle. `result` loads only in a cycle where `valid_in` is high and holds its value otherwise.
- R3: `lane_size` code 1 selects 16-bit lanes and code 2 selects 8-bit lanes. Codes 0 and 3 select 32-bit lanes. Opcode 0 adds the lanes of `op_a` and `op_b` modulo the lane width, with no carry into the next lane.
- R4: Opcode 1 computes `op_a` minus `op_b` in each lane, modulo the lane width, with no borrow from the next lane.
- R5: Opcode 2 returns the smaller and opcode 3 the larger lane of the two operands, comparing lanes as signed two's-complement values.
- R6: Opcodes 4, 5, 6 and 7 compute AND, OR, XOR and NOR over the full 128 bits, whatever the lane size.
- R7: Opcodes 8, 9 and 10 shift each lane of `op_a` left, logically right and arithmetically right. Each uses only the low log2(lane width) bits of `shamt`, and `op_b` has no effect.
- R8: Opcode 11 writes, right-aligned in each lane, the number of leading zeros of that lane of `op_a`. An all-zero lane yields the lane width.
- R9: Opcode 12 returns bits [shamt+127 : shamt] of the 256-bit value {`op_a`, `op_b`} (`op_a` in the upper half), regardless of lane size. A shift of 0 returns `op_b`.
- R10: Opcodes 13, 14 and 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operation strobe |
| opcode | input | 4 | Operation select |
| lane_size | input | 2 | Lane width code |
| shamt | input | 7 | Shift amount |
| op_a | input | 128 | First operand (upper half for funnel) |
| op_b | input | 128 | Second operand (lower half for funnel) |
| valid_out | output | 1 | Result valid, one cycle after `valid_in` |
| result | output | 128 | Registered result |

## Verification
The bench places all-ones and sign-bit patterns at lane edges. A unit that leaks a carry or borrow would corrupt the neighbouring lane, and a unit that compares unsigned would pick the wrong value for min and max. It uses shift amounts larger than the lane, which a unit that does not mask the amount would zero out. It also uses zero lanes for the count, where a faulty counter would return width-1 or zero. Funnel shifts of 0 and 127 expose an off-by-one window. Idle cycles with changed inputs, undefined opcodes, lane code 3 and a reset in the middle of a run check that the register does not load stray values and that reserved codes are decoded.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_MIN  = 4'd2,
      OP_MAX  = 4'd3,
      OP_AND  = 4'd4,
      OP_OR   = 4'd5,
      OP_XOR  = 4'd6,
      OP_NOR  = 4'd7,
      OP_SLL  = 4'd8,
      OP_SRL  = 4'd9,
      OP_SRA  = 4'd10,
      OP_CLZ  = 4'd11,
      OP_FSHR = 4'd12,
      OP_RSV0 = 4'd13,
      OP_RSV1 = 4'd14,
      OP_RSV2 = 4'd15
   } simd_op_e;

   localparam logic [1:0] LSZ_WIDE   = 2'd0;
   localparam logic [1:0] LSZ_MID    = 2'd1;
   localparam logic [1:0] LSZ_NARROW = 2'd2;

   function automatic logic is_lane_op(simd_op_e op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MIN) ||
             (op == OP_MAX) || (op == OP_SLL) || (op == OP_SRL) ||
             (op == OP_SRA) || (op == OP_CLZ);
   endfunction

   function automatic logic is_bitwise_op(simd_op_e op);
      return (op == OP_AND) || (op == OP_OR) ||
             (op == OP_XOR) || (op == OP_NOR);
   endfunction

endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
   import simd_alu_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int LANE_W = 32,
   localparam int LANES  = DATA_W / LANE_W,
   localparam int SH_W   = $clog2(LANE_W),
   localparam int CNT_W  = $clog2(LANE_W) + 1
) (
   input  simd_op_e          op,
   input  logic [SH_W-1:0]   lane_sh,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res
);

   if (LANE_W < 2 || (1 << SH_W) != LANE_W) begin : g_bad_lane
      $error("simd_lane_unit: LANE_W must be a power of two of at least 2");
   end
   if (DATA_W % LANE_W != 0) begin : g_bad_split
      $error("simd_lane_unit: DATA_W must be a multiple of LANE_W");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] la;
      logic [LANE_W-1:0] lb;
      logic [LANE_W-1:0] lr;
      logic [CNT_W-1:0]  lz;

      assign la = a[l*LANE_W +: LANE_W];
      assign lb = b[l*LANE_W +: LANE_W];

      always_comb begin
         lz = CNT_W'(LANE_W);
         for (int j = 0; j < LANE_W; j++) begin
            if (la[j]) lz = CNT_W'(LANE_W - 1 - j);
         end
      end

      always_comb begin
         case (op)
            OP_ADD:  lr = la + lb;
            OP_SUB:  lr = la - lb;
            OP_MIN:  lr = ($signed(la) < $signed(lb)) ? la : lb;
            OP_MAX:  lr = ($signed(la) > $signed(lb)) ? la : lb;
            OP_SLL:  lr = la << lane_sh;
            OP_SRL:  lr = la >> lane_sh;
            OP_SRA:  lr = LANE_W'($signed(la) >>> lane_sh);
            OP_CLZ:  lr = LANE_W'(lz);
            default: lr = '0;
         endcase
      end

      assign res[l*LANE_W +: LANE_W] = lr;
   end

endmodule

// File: rtl/simd_bitwise.sv
module simd_bitwise
   import simd_alu_pkg::*;
#(
   parameter int DATA_W = 128
) (
   input  simd_op_e          op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res
);

   always_comb begin
      case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_NOR:  res = ~(a | b);
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/simd_funnel.sv
module simd_funnel #(
   parameter int DATA_W = 128,
   localparam int SHAMT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0]  hi,
   input  logic [DATA_W-1:0]  lo,
   input  logic [SHAMT_W-1:0] sh,
   output logic [DATA_W-1:0]  window
);

   logic [2*DATA_W-1:0] joined;

   assign joined = {hi, lo};
   assign window = DATA_W'(joined >> sh);

endmodule

// File: rtl/simd_alu.sv
module simd_alu
   import simd_alu_pkg::*;
#(
   parameter int DATA_W     = 128,
   parameter int MIN_LANE_W = 8,
   parameter int NUM_SIZES  = 3,
   localparam int SHAMT_W   = $clog2(DATA_W),
   localparam int MAX_LANE_W = MIN_LANE_W << (NUM_SIZES - 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid_in,
   input  logic [3:0]         opcode,
   input  logic [1:0]         lane_size,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic [DATA_W-1:0]  op_a,
   input  logic [DATA_W-1:0]  op_b,
   output logic               valid_out,
   output logic [DATA_W-1:0]  result
);

   if (NUM_SIZES != 3) begin : g_bad_sizes
      $error("simd_alu: the lane-size code decodes exactly three widths");
   end
   if (DATA_W % MAX_LANE_W != 0) begin : g_bad_width
      $error("simd_alu: DATA_W must be a multiple of the widest lane");
   end
   if ((1 << SHAMT_W) != DATA_W) begin : g_bad_pow2
      $error("simd_alu: DATA_W must be a power of two");
   end

   simd_op_e op;
   assign op = simd_op_e'(opcode);

   // Index 0 is the narrowest lane size, index NUM_SIZES-1 the widest.
   logic [DATA_W-1:0] lane_res [NUM_SIZES];

   for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
      localparam int LW = MIN_LANE_W << k;
      localparam int LSW = $clog2(LW);

      simd_lane_unit #(
         .DATA_W (DATA_W),
         .LANE_W (LW)
      ) u_lane (
         .op      (op),
         .lane_sh (shamt[LSW-1:0]),
         .a       (op_a),
         .b       (op_b),
         .res     (lane_res[k])
      );
   end

   logic [DATA_W-1:0] bw_res;
   logic [DATA_W-1:0] fn_res;
   logic [DATA_W-1:0] lane_pick;
   logic [DATA_W-1:0] result_d;

   simd_bitwise #(
      .DATA_W (DATA_W)
   ) u_bitwise (
      .op  (op),
      .a   (op_a),
      .b   (op_b),
      .res (bw_res)
   );

   simd_funnel #(
      .DATA_W (DATA_W)
   ) u_funnel (
      .hi     (op_a),
      .lo     (op_b),
      .sh     (shamt),
      .window (fn_res)
   );

   always_comb begin
      case (lane_size)
         LSZ_MID:    lane_pick = lane_res[1];
         LSZ_NARROW: lane_pick = lane_res[0];
         default:    lane_pick = lane_res[NUM_SIZES-1];
      endcase
   end

   always_comb begin
      if (is_lane_op(op))          result_d = lane_pick;
      else if (is_bitwise_op(op))  result_d = bw_res;
      else if (op == OP_FSHR)      result_d = fn_res;
      else                         result_d = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_out <= 1'b0;
         result    <= '0;
      end else begin
         valid_out <= valid_in;
         if (valid_in) result <= result_d;
      end
   end

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk
   import simd_alu_pkg::*;
#(
   parameter int DATA_W  = 128,
   parameter int SHAMT_W = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               valid_in,
   input logic [3:0]         opcode,
   input logic [1:0]         lane_size,
   input logic [SHAMT_W-1:0] shamt,
   input logic [DATA_W-1:0]  op_a,
   input logic [DATA_W-1:0]  op_b,
   input logic               valid_out,
   input logic [DATA_W-1:0]  result
);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (!valid_out && result == '0));

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> valid_out);

   // R2
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> !valid_out);

   // R2
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> $stable(result));

   // R6
   xor_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && opcode == OP_XOR) |=> result == $past(op_a ^ op_b));

   // R8
   clz_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && opcode == OP_CLZ && lane_size == LSZ_NARROW && op_a == '0)
      |=> result == {(DATA_W/8){8'd8}});

   // R9
   funnel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && opcode == OP_FSHR && shamt == '0) |=> result == $past(op_b));

   // R10
   reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && opcode >= 4'd13) |=> result == '0);

endmodule

bind simd_alu simd_alu_chk #(
   .DATA_W  (DATA_W),
   .SHAMT_W (SHAMT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .valid_in  (valid_in),
   .opcode    (opcode),
   .lane_size (lane_size),
   .shamt     (shamt),
   .op_a      (op_a),
   .op_b      (op_b),
   .valid_out (valid_out),
   .result    (result)
);

// File: tb/simd_alu_tb.sv
module simd_alu_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         valid_in = 1'b0;
   logic [3:0]   opcode = '0;
   logic [1:0]   lane_size = '0;
   logic [6:0]   shamt = '0;
   logic [127:0] op_a = '0;
   logic [127:0] op_b = '0;
   logic         valid_out;
   logic [127:0] result;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   simd_alu u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_in  (valid_in),
      .opcode    (opcode),
      .lane_size (lane_size),
      .shamt     (shamt),
      .op_a      (op_a),
      .op_b      (op_b),
      .valid_out (valid_out),
      .result    (result)
   );

   function automatic logic [127:0] model(int op, int ls, int sh,
                                          logic [127:0] a, logic [127:0] b);
      logic [127:0] r;
      logic [255:0] cat;
      int w;
      longint unsigned m;
      r = '0;
      case (op)
         4: return a & b;
         5: return a | b;
         6: return a ^ b;
         7: return ~(a | b);
         12: begin
            cat = {a, b};
            cat = cat >> sh;
            return cat[127:0];
         end
         13, 14, 15: return '0;
         default: ;
      endcase
      w = (ls == 1) ? 16 : (ls == 2) ? 8 : 32;
      m = (64'd1 << w) - 64'd1;
      for (int i = 0; i < 128 / w; i++) begin
         longint unsigned ua, ub, ru;
         longint sa, sb;
         int s;
         ua = 64'(a >> (i * w)) & m;
         ub = 64'(b >> (i * w)) & m;
         sa = longint'(ua) - (ua[w-1] ? longint'(64'd1 << w) : 64'sd0);
         sb = longint'(ub) - (ub[w-1] ? longint'(64'd1 << w) : 64'sd0);
         s = sh % w;
         case (op)
            0: ru = (ua + ub) & m;
            1: ru = (ua - ub) & m;
            2: ru = (sa < sb) ? ua : ub;
            3: ru = (sa > sb) ? ua : ub;
            8: ru = (ua << s) & m;
            9: ru = ua >> s;
            10: ru = longint'(sa >>> s) & m;
            default: begin
               ru = 64'(w);
               for (int j = 0; j < w; j++) if (ua[j]) ru = 64'(w - 1 - j);
            end
         endcase
         r = r | (128'(ru) << (i * w));
      end
      return r;
   endfunction

   task automatic chk(logic [127:0] got, logic [127:0] exp, string req, string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got %h exp %h", req, what, got, exp);
      end
   endtask

   task automatic run_op(int op, int ls, int sh, logic [127:0] a,
                         logic [127:0] b, string req, string what);
      @(negedge clk);
      opcode = 4'(op); lane_size = 2'(ls); shamt = 7'(sh);
      op_a = a; op_b = b; valid_in = 1'b1;
      @(negedge clk);
      valid_in = 1'b0;
      chk(result, model(op, ls, sh, a, b), req, what);
      chk(128'(valid_out), 128'd1, "R2", {what, " valid"});
   endtask

   initial begin
      logic [127:0] held;
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(result, '0, "R1", "reset result");
      chk(128'(valid_out), 128'd0, "R1", "reset valid");
      @(negedge clk);
      rst_n = 1'b1;

      // R3 add: carry must stop at lane edges
      run_op(0, 0, 0, {4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, "R3", "add32 wrap");
      run_op(0, 2, 0, {16{8'hFF}}, {16{8'h01}}, "R3", "add8 wrap");
      run_op(0, 1, 0, {8{16'h8001}}, {8{16'hFFFF}}, "R3", "add16");
      run_op(0, 3, 0, {4{32'hFFFF_FFFF}}, {4{32'h1}}, "R3", "lane code 3 as 32");
      // R4 subtract: borrow must stop at lane edges
      run_op(1, 2, 0, '0, {16{8'h01}}, "R4", "sub8 borrow");
      run_op(1, 0, 0, {4{32'h0}}, {4{32'h1}}, "R4", "sub32 borrow");
      // R5 signed min/max
      run_op(2, 2, 0, {16{8'h80}}, {16{8'h7F}}, "R5", "min8 signed");
      run_op(3, 1, 0, {8{16'h8000}}, {8{16'h0001}}, "R5", "max16 signed");
      run_op(2, 0, 0, {32'h8000_0000, 32'h7FFF_FFFF, 32'h5, 32'hFFFF_FFFF},
             {32'h7FFF_FFFF, 32'h8000_0000, 32'h5, 32'h0}, "R5", "min32 mixed");
      // R6 bitwise
      run_op(4, 2, 0, {2{64'hF0F0_1234_AAAA_0F0F}}, {2{64'h0FF0_FFFF_5555_00FF}}, "R6", "and");
      run_op(7, 1, 0, {2{64'hF0F0_1234_AAAA_0F0F}}, {2{64'h0FF0_FFFF_5555_00FF}}, "R6", "nor");
      // R7 shifts, amount masked to lane, op_b ignored
      run_op(8, 2, 9, {16{8'h81}}, {16{8'hFF}}, "R7", "sll8 amount 9");
      run_op(10, 1, 15, {8{16'h8000}}, '1, "R7", "sra16 by 15");
      run_op(9, 0, 33, {4{32'h8000_0000}}, '0, "R7", "srl32 amount 33");
      run_op(10, 0, 31, {4{32'h4000_0000}}, '0, "R7", "sra32 positive");
      // R8 leading zeros
      run_op(11, 2, 0, '0, '0, "R8", "clz8 zero");
      run_op(11, 0, 0, {32'h0, 32'h1, 32'h8000_0000, 32'h0001_0000}, '0, "R8", "clz32");
      run_op(11, 1, 0, {16'h0, 16'h1, 16'h8000, 16'h00F0, 64'h0}, '0, "R8", "clz16");
      // R9 funnel
      run_op(12, 0, 0, {4{32'hAAAA_5555}}, {4{32'h1234_5678}}, "R9", "funnel 0");
      run_op(12, 1, 127, {4{32'hAAAA_5555}}, {4{32'h1234_5678}}, "R9", "funnel 127");
      run_op(12, 2, 64, {2{64'hDEAD_BEEF_0BAD_F00D}}, {2{64'h1}}, "R9", "funnel 64");
      // R10 reserved opcodes
      run_op(13, 0, 5, '1, '1, "R10", "op13");
      run_op(15, 2, 5, '1, '1, "R10", "op15");

      // R2 hold while idle
      run_op(0, 0, 0, {4{32'h11}}, {4{32'h22}}, "R2", "preload");
      held = result;
      @(negedge clk);
      opcode = 4'd6; op_a = '1; op_b = '0; valid_in = 1'b0;
      @(negedge clk);
      chk(result, held, "R2", "hold while idle");
      chk(128'(valid_out), 128'd0, "R2", "valid low while idle");

      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic [127:0] ra, rb;
         int sel;
         ra = {$urandom, $urandom, $urandom, $urandom};
         rb = {$urandom, $urandom, $urandom, $urandom};
         sel = int'($urandom % 8);
         if (sel == 0) ra = '0;
         if (sel == 1) rb = '1;
         if (sel == 2) ra = ra & {16{8'h0F}};
         run_op(int'($urandom % 16), int'($urandom % 4), int'($urandom % 128),
                ra, rb, "R3-R10 random", "random op");
      end

      // R1 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(result, '0, "R1", "reset mid-run result");
      chk(128'(valid_out), 128'd0, "R1", "reset mid-run valid");

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish got timeout exp completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule